// File: doc/BRIEF.md
# Delta-Sample Fetch DMA Engine

This block pulls sample bytes out of processor memory at a programmed pace for a delta-modulation audio channel. Software sets the pacing rate, a start block and a length through a small byte-wide register port, then turns the engine on through a shared status register. The engine counts processor cycles. Each time the selected period expires, it raises a read request on a 16-bit address bus and holds it until the bus grants it. It also asserts a stall line so that the processor loses a fixed number of cycles for every byte fetched.

At the end of a sample, the engine behaves in one of two ways. If looping is selected, it starts the same sample again. Otherwise it stops and, if interrupts are enabled, latches an interrupt flag. The processor can read that flag from the status register, and the read clears it. The byte decoder and the output converter are outside this block. The register that would load the converter directly is accepted but has no effect.

Top module: `dsample_dma`

## Requirements
- R1: Control register (select 0) decodes bit 7 as interrupt enable, bit 6 as loop, and bits 3:0 as rate index. The other selects are 1 for direct load, 2 for sample base, 3 for sample length and 4 for status.
- R2: While running, requests are spaced by the period picked by the rate index from the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 85, 72, 54 (index 0 first). This holds when the bus grants within the period.
- R3: A reload sets the address to 0xC000 + (base << 6) and the byte count to length << 4.
- R4: The address increments after every fetch, and the address following 0xFFFF is 0x8000.
- R5: When the count reaches zero with loop clear, the engine stops. If interrupt enable is set, it also raises irq_o.
- R6: When the count reaches zero with loop set, the engine reloads address and count and keeps fetching with no interrupt.
- R7: Writing status bit 4 as 1 sets the enable. It reloads address and count only if the engine was disabled or had no bytes left. Writing bit 4 as 0 stops further fetches.
- R8: A status read returns bit 4 = byte count nonzero and bit 6 = interrupt flag, with all other bits 0. The read clears the interrupt flag.
- R9: A request stays asserted with a stable address until mem_ack_i is seen.
- R10: Each granted fetch asserts stall_o for exactly 4 cycles.
- R11: Writes to the direct-load register change neither the fetch stream nor the status.
- R12: A length of 0 produces no fetch and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor-cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Status read data (zero unless status is read) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Bus grant for the pending request |
| stall_o | output | 1 | Processor stall |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench runs one 16-byte sample at every rate index and measures the cycle gap between grants against the period table. A wrong table entry or an off-by-one terminal count shows up as a gap that is one cycle off. An 80-byte sample from the highest base crosses the top of memory. A design that wraps to zero, or does not wrap, emits addresses below 0x8000. Re-enabling while the engine is running must not rewind the stream, and re-enabling after a stop must rewind to the new base. A design that reloads unconditionally repeats addresses, and one that never reloads continues the old stream. Further runs cover a delayed grant, looping, the interrupt flag and its clear on read, a zero length, and a direct-load write. Under these, a design that drops its request early, counts the stall wrong, or fires on an empty count is caught by the grant count, the stall cycle count, or a stray fetch.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int unsigned TMR_W     = 9;
  localparam int unsigned CNT_W     = 12;
  localparam int unsigned ADR_W     = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BASE_SH   = 6;
  localparam int unsigned LEN_SH    = 4;
  localparam logic [ADR_W-1:0] ADR_START = 16'hC000;
  localparam logic [ADR_W-1:0] ADR_WRAP  = 16'h8000;
  localparam int unsigned ST_BUSY_BIT = 4;
  localparam int unsigned ST_IRQ_BIT  = 6;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_DIRECT = 3'd1,
    SEL_BASE   = 3'd2,
    SEL_LEN    = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic       irq_en;
    logic       loop;
    logic [1:0] rsvd;
    logic [3:0] rate;
  } ctrl_t;

  function automatic logic [TMR_W-1:0] rate_period(input logic [3:0] idx);
    logic [TMR_W-1:0] p;
    case (idx)
      4'd0:    p = 9'd428;
      4'd1:    p = 9'd380;
      4'd2:    p = 9'd340;
      4'd3:    p = 9'd320;
      4'd4:    p = 9'd286;
      4'd5:    p = 9'd254;
      4'd6:    p = 9'd226;
      4'd7:    p = 9'd214;
      4'd8:    p = 9'd190;
      4'd9:    p = 9'd160;
      4'd10:   p = 9'd142;
      4'd11:   p = 9'd128;
      4'd12:   p = 9'd106;
      4'd13:   p = 9'd85;
      4'd14:   p = 9'd72;
      default: p = 9'd54;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] base_o,
  output logic [BYTE_W-1:0] len_o,
  output logic              en_o,
  output logic              reload_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] base_q, len_q;
  logic              en_q, irq_q;
  logic              status_wr, status_rd;

  assign status_wr = wr_i && (sel_i == SEL_STATUS);
  assign status_rd = rd_i && (sel_i == SEL_STATUS);
  // restart only when idle or drained
  assign reload_o  = status_wr && wdata_i[ST_BUSY_BIT] && (!en_q || !busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_CTRL: ctrl_q <= ctrl_t'(wdata_i);
        SEL_BASE: base_q <= wdata_i;
        SEL_LEN:  len_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (status_wr) en_q <= wdata_i[ST_BUSY_BIT];
    else if (done_i)    en_q <= 1'b0;
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     irq_q <= 1'b0;
    else if (done_i && ctrl_q.irq_en) irq_q <= 1'b1;
    else if (status_rd)              irq_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (status_rd) begin
      rdata_o[ST_BUSY_BIT] = busy_i;
      rdata_o[ST_IRQ_BIT]  = irq_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign base_o = base_q;
  assign len_o  = len_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ctrl_q.irq_en |=> irq_o); // R5
  AST_STOP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !status_wr |=> !en_o); // R5
  AST_IRQ_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd && !done_i |=> !irq_o); // R8
endmodule

// File: rtl/dsf_timer.sv
module dsf_timer
  import dsf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       hold_i,
  input  logic [3:0] rate_i,
  output logic       fire_o
);
  logic [TMR_W-1:0] tmr_q, lim;

  assign lim    = rate_period(rate_i) - 1'b1;
  // waits at the limit while a request is still outstanding
  assign fire_o = run_i && !hold_i && (tmr_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (fire_o)               tmr_q <= '0;
    else if (run_i && tmr_q < lim) tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/dsf_fetch.sv
module dsf_fetch
  import dsf_pkg::*;
#(
  parameter int unsigned STALL_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              reload_i,
  input  logic [BYTE_W-1:0] base_i,
  input  logic [BYTE_W-1:0] len_i,
  input  logic              loop_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADR_W-1:0]  mem_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              stall_o
);
  localparam int unsigned SW = $clog2(STALL_CYC + 1);

  logic [ADR_W-1:0] ptr_q, req_addr_q, start_adr;
  logic [CNT_W-1:0] cnt_q, start_cnt;
  logic [SW-1:0]    stall_q;
  logic             req_q, take, last;

  assign start_adr = ADR_START + (ADR_W'(base_i) << BASE_SH);
  assign start_cnt = CNT_W'(len_i) << LEN_SH;
  assign take      = req_q && mem_ack_i;
  assign last      = take && (cnt_q == CNT_W'(1));
  assign done_o    = last && !loop_i;
  assign busy_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= ADR_START;
      cnt_q <= '0;
    end else if (reload_i) begin
      ptr_q <= start_adr;
      cnt_q <= start_cnt;
    end else if (take) begin
      if (last && loop_i) begin
        ptr_q <= start_adr;
        cnt_q <= start_cnt;
      end else begin
        ptr_q <= (ptr_q == '1) ? ADR_WRAP : ptr_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      req_addr_q <= '0;
    end else if (fire_i) begin
      req_q      <= 1'b1;
      req_addr_q <= ptr_q;
    end else if (take) begin
      req_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               stall_q <= '0;
    else if (take)             stall_q <= SW'(STALL_CYC);
    else if (stall_q != '0)    stall_q <= stall_q - 1'b1;
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = req_addr_q;
  assign stall_o    = (stall_q != '0);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R9
  AST_UPPER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[ADR_W-1]); // R4
  AST_STALL_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> stall_o); // R10
  AST_NO_FETCH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(busy_o)); // R12
endmodule

// File: rtl/dsample_dma.sv
module dsample_dma
  import dsf_pkg::*;
#(
  parameter int unsigned STALL_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        mem_req_o,
  output logic [15:0] mem_addr_o,
  input  logic        mem_ack_i,
  output logic        stall_o,
  output logic        irq_o
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] base, len;
  logic              en, reload, busy, done, fire;

  dsf_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy),
    .done_i   (done),
    .ctrl_o   (ctrl),
    .base_o   (base),
    .len_o    (len),
    .en_o     (en),
    .reload_o (reload),
    .irq_o    (irq_o)
  );

  dsf_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en && busy),
    .hold_i (mem_req_o),
    .rate_i (ctrl.rate),
    .fire_o (fire)
  );

  dsf_fetch #(.STALL_CYC(STALL_CYC)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .reload_i   (reload),
    .base_i     (base),
    .len_i      (len),
    .loop_i     (ctrl.loop),
    .mem_ack_i  (mem_ack_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy),
    .done_o     (done),
    .stall_o    (stall_o)
  );
endmodule

// File: tb/dsample_dma_bench.sv
module dsample_dma_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_wr, reg_rd;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        mem_req, mem_ack, stall, irq;
  logic [15:0] mem_addr;

  dsample_dma u_dsample_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .stall_o(stall), .irq_o(irq)
  );

  int ack_delay = 0;
  int req_age = 0;
  assign mem_ack = mem_req && (req_age >= ack_delay);
  always @(posedge clk) req_age <= (mem_req && !mem_ack) ? req_age + 1 : 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int fetch_n = 0, stall_n = 0, req_n = 0;
  int          f_cyc [512];
  logic [15:0] f_adr [512];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      if (fetch_n < 512) begin
        f_cyc[fetch_n] = cyc;
        f_adr[fetch_n] = mem_addr;
      end
      fetch_n++;
    end
    if (stall)   stall_n++;
    if (mem_req) req_n++;
  end

  function automatic int period(input int r);
    case (r)
      0: return 428;  1: return 380;  2: return 340;  3: return 320;
      4: return 286;  5: return 254;  6: return 226;  7: return 214;
      8: return 190;  9: return 160; 10: return 142; 11: return 128;
      12: return 106; 13: return 85; 14: return 72;  default: return 54;
    endcase
  endfunction

  function automatic int exp_adr(input int start, input int k);
    int a = start + k;
    if (a > 'hFFFF) a = a - 'h10000 + 'h8000;
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 3'd4;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_f(input int target, input int limit, input string tag);
    int t = 0;
    while (fetch_n < target && t < limit) begin
      @(negedge clk);
      t++;
    end
    chk(fetch_n >= target, tag, fetch_n, target);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int b, bad, s0, r0, m;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(!irq && !stall && !mem_req, "reset outputs", {irq, stall, mem_req}, 0);
    rd_stat(st);
    chk(st == 8'h00, "R8 reset status", st, 0);

    // R2 R3 R10: one sample per rate index
    for (int r = 0; r < 16; r++) begin
      int base = r * 16 + 3;
      int start = 'hC000 + (base << 6);
      b = fetch_n; s0 = stall_n;
      wr(3'd0, 8'(r));           // R1 rate field
      wr(3'd2, 8'(base));
      wr(3'd3, 8'd1);
      wr(3'd4, 8'h10);
      wait_f(b + 16, 16 * 450 + 100, "R2 sample completes");
      repeat (8) @(negedge clk);
      bad = 0;
      for (int k = 1; k < 16; k++)
        if (f_cyc[b+k] - f_cyc[b+k-1] != period(r)) bad++;
      chk(bad == 0, $sformatf("R2 gap rate %0d", r), f_cyc[b+1] - f_cyc[b], period(r));
      bad = 0;
      for (int k = 0; k < 16; k++)
        if (int'(f_adr[b+k]) != start + k) bad++;
      chk(bad == 0, "R3 address sequence", f_adr[b], start);
      chk(fetch_n == b + 16, "R3 byte count len<<4", fetch_n - b, 16);
      chk(stall_n - s0 == 64, "R10 stall cycles", stall_n - s0, 64);
      rd_stat(st);
      chk(st == 8'h00, "R5 stop without irq", st, 0);
    end

    // R4 wrap through the top of memory
    b = fetch_n;
    wr(3'd0, 8'h0F); wr(3'd2, 8'hFF); wr(3'd3, 8'd5); wr(3'd4, 8'h10);
    wait_f(b + 80, 80 * 60 + 100, "R4 sample completes");
    bad = 0;
    for (int k = 0; k < 80; k++)
      if (int'(f_adr[b+k]) != exp_adr('hFFC0, k)) bad++;
    chk(bad == 0, "R4 wrapped sequence", f_adr[b+79], exp_adr('hFFC0, 79));
    chk(f_adr[b+64] == 16'h8000, "R4 wrap target", f_adr[b+64], 'h8000);
    repeat (8) @(negedge clk);

    // R5 R8 interrupt at end, clear on read
    b = fetch_n;
    wr(3'd0, 8'h8F); wr(3'd2, 8'h10); wr(3'd3, 8'd1); wr(3'd4, 8'h10);
    wait_f(b + 16, 16 * 60 + 100, "R5 sample completes");
    repeat (3) @(negedge clk);
    chk(irq, "R5 irq raised", irq, 1);
    rd_stat(st);
    chk(st == 8'h40, "R8 status shows irq", st, 'h40);
    chk(!irq, "R8 irq cleared by read", irq, 0);
    rd_stat(st);
    chk(st == 8'h00, "R8 second read", st, 0);
    m = fetch_n;
    repeat (200) @(negedge clk);
    chk(fetch_n == m, "R5 engine stopped", fetch_n, m);

    // R6 loop, R7 restart while busy, R11 direct load
    b = fetch_n;
    wr(3'd0, 8'h4F); wr(3'd2, 8'h20); wr(3'd3, 8'd1); wr(3'd4, 8'h10);
    wait_f(b + 20, 20 * 60 + 100, "R6 loop progress");
    chk(f_adr[b+16] == 16'hC800, "R6 loop restarts", f_adr[b+16], 'hC800);
    chk(f_adr[b+19] == 16'hC803, "R6 loop continues", f_adr[b+19], 'hC803);
    chk(!irq, "R6 no irq on loop", irq, 0);
    wr(3'd2, 8'h30); wr(3'd4, 8'h10);
    wait_f(b + 24, 4 * 60 + 100, "R7 progress");
    bad = 0;
    for (int k = 20; k < 24; k++)
      if (int'(f_adr[b+k]) != 'hC800 + (k % 16)) bad++;
    chk(bad == 0, "R7 no reload while busy", f_adr[b+20], 'hC800 + 4);
    wr(3'd1, 8'h7F);
    wait_f(b + 28, 4 * 60 + 100, "R11 progress");
    bad = 0;
    for (int k = 24; k < 28; k++)
      if (int'(f_adr[b+k]) != 'hC800 + (k % 16)) bad++;
    chk(bad == 0, "R11 direct load ignored", f_adr[b+24], 'hC800 + 8);
    rd_stat(st);
    chk(st == 8'h10, "R11 status unchanged", st, 'h10);
    wr(3'd4, 8'h00);
    repeat (3) @(negedge clk);
    m = fetch_n;
    repeat (200) @(negedge clk);
    chk(fetch_n == m, "R7 disable stops fetches", fetch_n, m);
    rd_stat(st);
    chk(st == 8'h10, "R8 bytes left while disabled", st, 'h10);
    m = fetch_n;
    wr(3'd4, 8'h10);
    wait_f(m + 1, 100, "R7 restart progress");
    chk(f_adr[m] == 16'hCC00, "R7 reload after disable", f_adr[m], 'hCC00);
    wr(3'd0, 8'h0F);
    wait_f(m + 16, 16 * 60 + 100, "R7 final sample");
    repeat (8) @(negedge clk);
    rd_stat(st);
    chk(st == 8'h00, "R5 drained after loop off", st, 0);

    // R9 delayed grant
    ack_delay = 5;
    b = fetch_n; s0 = stall_n; r0 = req_n;
    wr(3'd2, 8'h40); wr(3'd3, 8'd1); wr(3'd4, 8'h10);
    wait_f(b + 16, 16 * 60 + 200, "R9 sample completes");
    repeat (8) @(negedge clk);
    bad = 0;
    for (int k = 1; k < 16; k++)
      if (f_cyc[b+k] - f_cyc[b+k-1] != 54) bad++;
    chk(bad == 0, "R9 gap with late grant", f_cyc[b+1] - f_cyc[b], 54);
    chk(req_n - r0 == 96, "R9 request held to grant", req_n - r0, 96);
    chk(stall_n - s0 == 64, "R10 stall with late grant", stall_n - s0, 64);
    bad = 0;
    for (int k = 0; k < 16; k++)
      if (int'(f_adr[b+k]) != 'hD000 + k) bad++;
    chk(bad == 0, "R9 addresses", f_adr[b], 'hD000);
    ack_delay = 0;

    // R12 zero length
    m = fetch_n;
    wr(3'd0, 8'h8F); wr(3'd3, 8'd0); wr(3'd4, 8'h10);
    repeat (300) @(negedge clk);
    chk(fetch_n == m, "R12 no fetch", fetch_n, m);
    chk(!irq, "R12 no irq", irq, 0);
    rd_stat(st);
    chk(st == 8'h00, "R12 status idle", st, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule